// File: doc/BRIEF.md
# Wait-Stretchable PIO Bus Cycle Sequencer

This block runs one 16-bit programmed-I/O transfer on a chip-select region that has an IDE-style device behind it. A host presents a request: direction, address, write data, and a timing set. The timing set has four phase counts (address lead, chip-enable delay, strobe width, hold), a two-bit multiplier code and a wait-mode enable. The block then sequences address, chip select, the read strobe (output enable) or the write strobe (write enable), and the write-data driver. It captures read data and reports completion with a one-clock acknowledge.

Every phase count N gives a phase of N+1 units, and each unit is a number of clocks picked by the multiplier code. When wait mode is on, the device can lengthen the strobe by holding its ready line low. The ready line goes through a synchronizer first. A limit counter ends a strobe that is stuck waiting and flags the transfer as timed out.

The request side is a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and all request and timing fields are latched on that edge. While a transfer is in flight the request inputs may change freely and have no effect. The response side carries no back-pressure: `rsp_ack` is a single-clock pulse, and `rsp_rdata` and `rsp_timeout` stay valid until the next request is taken.

Top module: `pio_cycle_seq`

## Requirements
- R1: After reset, `req_ready`=1, `rsp_ack`=0, `rsp_timeout`=0, `bus_dout_en`=0, and `bus_cs_n`, `bus_oe_n` and `bus_we_n` are all 1.
- R2: After a request is taken, `bus_addr` carries the request address and `bus_cs_n` stays 1 for exactly (adr+1)*U clocks before it falls. U is the unit length set by the multiplier code.
- R3: The multiplier code gives the unit length U as follows: code 0 gives 4 clocks, code 1 gives 1 clock, code 2 gives 2 clocks and code 3 gives 8 clocks.
- R4: After `bus_cs_n` falls, the strobe stays inactive for exactly (ce+1)*U clocks.
- R5: A read asserts only `bus_oe_n` (low) and a write asserts only `bus_we_n` (low). The two strobes are never low together, and neither is low while `bus_cs_n` is high. With wait mode off or the device ready, the strobe lasts exactly (strb+1)*U clocks.
- R6: After the strobe ends, `bus_cs_n` stays low for exactly (hold+1)*U clocks. `rsp_ack` is then high for exactly one clock, during which `bus_cs_n` is 1 and `req_ready` is 1.
- R7: On a read, `rsp_rdata` holds the value that `bus_din` had in the last clock of the strobe, which is the edge where `bus_oe_n` rises.
- R8: On a write, `bus_dout_en`=1 and `bus_dout` equals the write data for every clock in which `bus_cs_n` is low. On a read, `bus_dout_en` stays 0.
- R9: With wait mode on, the strobe continues while the synchronized `bus_iordy` is low. Suppose the ready line rises D clocks after the first strobe clock. The strobe then lasts max(L, D+3) clocks, where L=(strb+1)*U and the 3 accounts for the two-flop synchronizer.
- R10: With wait mode off, `bus_iordy` has no effect, and the strobe lasts L clocks even when the line is held low.
- R11: If the strobe has been extended past L for WAIT_LIMIT (256) clocks counted inclusively, the strobe ends anyway (length L-1+WAIT_LIMIT) and `rsp_timeout`=1 is reported with the acknowledge. Taking the next request clears `rsp_timeout` to 0.
- R12: A request is taken only when the sequencer is idle. `bus_addr` does not change during a transfer even if the request inputs do. A request held valid across the acknowledge clock is taken at the edge that ends that clock, so no idle clock is inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_addr | input | AW | Transfer address |
| req_wdata | input | 16 | Write data |
| cfg_adr | input | PW | Address lead count (minus-one) |
| cfg_ce | input | PW | Chip-enable-to-strobe count (minus-one) |
| cfg_strb | input | PW | Strobe width count (minus-one) |
| cfg_hold | input | PW | Hold count after strobe (minus-one) |
| cfg_mult | input | 2 | Unit length code: 0=4, 1=1, 2=2, 3=8 clocks |
| cfg_wait_en | input | 1 | Allow the device ready line to extend the strobe |
| bus_addr | output | AW | Address to the device |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_dout | output | 16 | Write data to the device |
| bus_dout_en | output | 1 | Write data driver enable |
| bus_din | input | 16 | Read data from the device |
| bus_iordy | input | 1 | Device ready, asynchronous |
| rsp_ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| rsp_timeout | output | 1 | Last transfer ended by the wait limit |

## Verification
Two events can fall in the same clock. The first is the acknowledge of one transfer together with the acceptance of the next. The bench provokes this by keeping `req_valid` high across a whole transfer with a different address. It then judges the result in two ways: `bus_addr` must not move during the first transfer, and the second transfer's address-phase count must start on the very next clock. The second pair is the device-ready release and the wait-limit expiry. Ready is released one clock before and exactly at the limit boundary. Both strobes come out 259 clocks long, so only `rsp_timeout` separates the two outcomes.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_CE   = 3'd2,
    PH_STRB = 3'd3,
    PH_HOLD = 3'd4
  } pio_phase_e;

  // Clocks per timing unit for each multiplier code.
  function automatic logic [3:0] unit_clocks(input logic [1:0] code);
    case (code)
      2'd0:    unit_clocks = 4'd4;
      2'd1:    unit_clocks = 4'd1;
      2'd2:    unit_clocks = 4'd2;
      default: unit_clocks = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int     STAGES  = 2,
  parameter logic   RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pio_phase_timer.sv
module pio_phase_timer #(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [PW-1:0] limit,
  input  logic [3:0]    unit,
  output logic          done
);
  logic [3:0]    ucnt;
  logic [PW-1:0] pcnt;
  logic [3:0]    unit_last;

  assign unit_last = unit - 4'd1;
  assign done      = (ucnt == unit_last) && (pcnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ucnt <= '0;
      pcnt <= '0;
    end else if (clear) begin
      ucnt <= '0;
      pcnt <= '0;
    end else if (!done) begin
      if (ucnt == unit_last) begin
        ucnt <= '0;
        pcnt <= pcnt + 1'b1;
      end else begin
        ucnt <= ucnt + 1'b1;
      end
    end
  end

  // R3: the unit counter never runs past the selected unit length
  assert_unit_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear) |-> (ucnt < unit));

  // R2: a counting phase never skips past its limit
  assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear) |-> (pcnt <= limit));
endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
  import pio_seq_pkg::*;
#(
  parameter int AW          = 8,
  parameter int PW          = 6,
  parameter int WAIT_LIMIT  = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [PW-1:0] cfg_adr,
  input  logic [PW-1:0] cfg_ce,
  input  logic [PW-1:0] cfg_strb,
  input  logic [PW-1:0] cfg_hold,
  input  logic [1:0]    cfg_mult,
  input  logic          cfg_wait_en,
  output logic [AW-1:0] bus_addr,
  output logic          bus_cs_n,
  output logic          bus_oe_n,
  output logic          bus_we_n,
  output logic [15:0]   bus_dout,
  output logic          bus_dout_en,
  input  logic [15:0]   bus_din,
  input  logic          bus_iordy,
  output logic          rsp_ack,
  output logic [15:0]   rsp_rdata,
  output logic          rsp_timeout
);
  localparam int WCW = $clog2(WAIT_LIMIT + 1);
  localparam logic [WCW-1:0] WLAST = WCW'(WAIT_LIMIT - 1);

  pio_phase_e    phase;
  logic          wr_q, wen_q;
  logic [AW-1:0] addr_q;
  logic [15:0]   wdata_q;
  logic [PW-1:0] f_adr, f_ce, f_strb, f_hold;
  logic [3:0]    unit_q;
  logic [WCW-1:0] wcnt;

  logic          iordy_s;
  logic          take, adv, stretch, cap_hit, tmr_done, tmr_clear;
  logic [PW-1:0] cur_limit;
  logic          in_cs, in_strb;

  pio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(bus_iordy), .q_sync(iordy_s)
  );

  always_comb begin
    case (phase)
      PH_ADDR: cur_limit = f_adr;
      PH_CE:   cur_limit = f_ce;
      PH_STRB: cur_limit = f_strb;
      PH_HOLD: cur_limit = f_hold;
      default: cur_limit = '0;
    endcase
  end

  pio_phase_timer #(.PW(PW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(tmr_clear),
    .limit(cur_limit), .unit(unit_q), .done(tmr_done)
  );

  assign req_ready = (phase == PH_IDLE);
  assign take      = req_ready && req_valid;
  assign in_strb   = (phase == PH_STRB);
  assign in_cs     = (phase == PH_CE) || in_strb || (phase == PH_HOLD);

  // Strobe is extended when its width is used up but the device is not ready.
  assign stretch = in_strb && tmr_done && wen_q && !iordy_s;
  assign cap_hit = stretch && (wcnt == WLAST);

  always_comb begin
    case (phase)
      PH_ADDR, PH_CE, PH_HOLD: adv = tmr_done;
      PH_STRB:                 adv = (tmr_done && !stretch) || cap_hit;
      default:                 adv = 1'b0;
    endcase
  end

  assign tmr_clear = (phase == PH_IDLE) || adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      wr_q    <= 1'b0;
      wen_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      f_adr   <= '0;
      f_ce    <= '0;
      f_strb  <= '0;
      f_hold  <= '0;
      unit_q  <= 4'd1;
    end else if (take) begin
      phase   <= PH_ADDR;
      wr_q    <= req_write;
      wen_q   <= cfg_wait_en;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      f_adr   <= cfg_adr;
      f_ce    <= cfg_ce;
      f_strb  <= cfg_strb;
      f_hold  <= cfg_hold;
      unit_q  <= unit_clocks(cfg_mult);
    end else if (adv) begin
      case (phase)
        PH_ADDR: phase <= PH_CE;
        PH_CE:   phase <= PH_STRB;
        PH_STRB: phase <= PH_HOLD;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt        <= '0;
      rsp_ack     <= 1'b0;
      rsp_rdata   <= '0;
      rsp_timeout <= 1'b0;
    end else begin
      rsp_ack <= (phase == PH_HOLD) && adv;
      if (take) begin
        wcnt        <= '0;
        rsp_timeout <= 1'b0;
      end else begin
        if (stretch && !cap_hit) wcnt <= wcnt + 1'b1;
        if (cap_hit)             rsp_timeout <= 1'b1;
      end
      if (in_strb && adv && !wr_q) rsp_rdata <= bus_din;
    end
  end

  assign bus_addr    = addr_q;
  assign bus_cs_n    = !in_cs;
  assign bus_oe_n    = !(in_strb && !wr_q);
  assign bus_we_n    = !(in_strb && wr_q);
  assign bus_dout    = wdata_q;
  assign bus_dout_en = in_cs && wr_q;

  // R5: no strobe outside chip select
  assert_strobe_in_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe_n || !bus_we_n) |-> !bus_cs_n);

  // R6: acknowledge is a single-clock pulse
  assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |=> !rsp_ack);

  // R6: acknowledge only comes when the bus is released
  assert_ack_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |-> (bus_cs_n && req_ready));

  // R12: address held stable while busy
  assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> $stable(bus_addr));

  // R11: wait counter stays below the limit
  assert_wait_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt < WCW'(WAIT_LIMIT));

  // R10: with wait mode off the strobe ends when its width is used up
  assert_nowait_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strb && tmr_done && !wen_q) |=> bus_oe_n && bus_we_n);
endmodule

// File: tb/pio_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module pio_cycle_seq_tb_top;
  localparam int AW = 8;
  localparam int PW = 6;
  localparam int LIMIT = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [PW-1:0] cfg_adr = '0, cfg_ce = '0, cfg_strb = '0, cfg_hold = '0;
  logic [1:0] cfg_mult = 2'd1;
  logic cfg_wait_en = 1'b0;
  logic [15:0] bus_din = '0;
  logic bus_iordy = 1'b1;
  logic req_ready, bus_cs_n, bus_oe_n, bus_we_n, bus_dout_en, rsp_ack, rsp_timeout;
  logic [AW-1:0] bus_addr;
  logic [15:0] bus_dout, rsp_rdata;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pio_cycle_seq #(.AW(AW), .PW(PW), .WAIT_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_adr(cfg_adr), .cfg_ce(cfg_ce), .cfg_strb(cfg_strb), .cfg_hold(cfg_hold),
    .cfg_mult(cfg_mult), .cfg_wait_en(cfg_wait_en),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
    .bus_iordy(bus_iordy), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .rsp_timeout(rsp_timeout)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R3: unit length per multiplier code
  function automatic int ucl(input int code);
    case (code)
      0: return 4;
      1: return 1;
      2: return 2;
      default: return 8;
    endcase
  endfunction

  function automatic logic [15:0] pat(input int k);
    return 16'hA55A ^ 16'(k * 257);
  endfunction

  // Expected strobe length (R5, R9, R10, R11); d < 0 means ready never driven low.
  function automatic int exp_strobe(input int len, input bit wen, input int d);
    if (!wen || d < 0) return len;
    if (d + 3 - len >= LIMIT) return len - 1 + LIMIT;
    return (len > d + 3) ? len : d + 3;
  endfunction

  function automatic bit exp_tmo(input int len, input bit wen, input int d);
    return wen && d >= 0 && (d + 3 - len >= LIMIT);
  endfunction

  task automatic measure(input bit wr, input logic [AW-1:0] addr, input logic [15:0] wd,
                         input int la, input int lc, input int ls, input int lh,
                         input bit terr, input bit keep);
    int a = 0, c = 0, s = 0, h = 0;
    bit both = 0, addr_bad = 0, dout_bad = 0, got_ack = 0;
    @(posedge clk); @(negedge clk);
    if (!keep) req_valid = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (rsp_ack) begin got_ack = 1; break; end
      if (bus_addr != addr) addr_bad = 1;
      if (!bus_oe_n && !bus_we_n) both = 1;
      if (bus_cs_n) a++;
      else begin
        if (wr ? !(bus_dout_en && bus_dout == wd) : bus_dout_en) dout_bad = 1;
        if (!bus_oe_n || !bus_we_n) begin
          if (wr ? !bus_oe_n : !bus_we_n) both = 1;
          bus_din = pat(s);
          s++;
        end else if (s == 0) c++;
        else begin h++; bus_din = 16'h0BAD; end
      end
      @(negedge clk);
    end
    chk(got_ack, "R6 ack seen", got_ack, 1);
    chk(a == la, "R2 R3 address phase clocks", a, la);
    chk(c == lc, "R4 R3 chip-enable delay clocks", c, lc);
    chk(s == ls, "R5 R9 R10 R11 strobe clocks", s, ls);
    chk(h == lh, "R6 hold clocks", h, lh);
    chk(!both, "R5 strobe exclusivity/direction", both, 0);
    chk(!addr_bad, "R12 R2 address stable", addr_bad, 0);
    chk(!dout_bad, "R8 write data drive", dout_bad, 0);
    chk(rsp_timeout == terr, "R11 timeout flag", rsp_timeout, terr);
    chk(req_ready && bus_cs_n, "R6 idle at ack", req_ready, 1);
    if (!wr) chk(rsp_rdata == pat(ls - 1), "R7 read data capture", rsp_rdata, pat(ls - 1));
    if (!keep) begin
      @(negedge clk);
      chk(!rsp_ack, "R6 ack single pulse", rsp_ack, 0);
    end
  endtask

  task automatic run(input bit wr, input logic [AW-1:0] addr, input logic [15:0] wd,
                     input int adr, input int ce, input int st, input int hd,
                     input int code, input bit wen, input int d, input bit keep);
    int u = ucl(code);
    int ls = exp_strobe((st + 1) * u, wen, d);
    bit te = exp_tmo((st + 1) * u, wen, d);
    req_write = wr; req_addr = addr; req_wdata = wd;
    cfg_adr = PW'(adr); cfg_ce = PW'(ce); cfg_strb = PW'(st); cfg_hold = PW'(hd);
    cfg_mult = 2'(code); cfg_wait_en = wen;
    if (d >= 0) bus_iordy = 1'b0;
    req_valid = 1'b1;
    fork
      measure(wr, addr, wd, (adr + 1) * u, (ce + 1) * u, ls, (hd + 1) * u, te, keep);
      begin
        if (d >= 0) begin
          @(posedge clk); @(negedge clk);
          while (bus_oe_n && bus_we_n) @(negedge clk);
          repeat (d) @(negedge clk);
          bus_iordy = 1'b1;
        end
      end
    join
    bus_iordy = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_ack && !rsp_timeout && !bus_dout_en, "R1 reset handshake", req_ready, 1);
    chk(bus_cs_n && bus_oe_n && bus_we_n, "R1 reset strobes", {bus_cs_n, bus_oe_n, bus_we_n}, 7);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep of multiplier codes, field values and both directions (R2-R8)
    for (int code = 0; code < 4; code++)
      for (int n = 0; n < 3; n++)
        for (int wr = 0; wr < 2; wr++)
          run(wr[0], AW'(code * 16 + n * 4 + wr), 16'(16'h1234 + code * 4099 + n * 77),
              n, (n + 1) % 3, (n + 2) % 3, 2 - n, code, 1'b0, -1, 1'b0);

    // R10: wait disabled, ready held low, strobe unchanged
    run(1'b0, 8'h40, 16'h0, 3, 0, 3, 0, 1, 1'b0, 50, 1'b0);
    // R9: wait enabled, release inside width and after width
    run(1'b0, 8'h41, 16'h0, 1, 1, 3, 1, 1, 1'b1, 0, 1'b0);
    run(1'b1, 8'h42, 16'hBEEF, 1, 1, 3, 1, 1, 1'b1, 5, 1'b0);
    run(1'b0, 8'h43, 16'h0, 0, 0, 1, 0, 2, 1'b1, 20, 1'b0);
    // R11 boundary: one short of the limit, then exactly at it
    run(1'b0, 8'h44, 16'h0, 0, 0, 3, 0, 1, 1'b1, 256, 1'b0);
    run(1'b0, 8'h45, 16'h0, 0, 0, 3, 0, 1, 1'b1, 257, 1'b0);
    run(1'b1, 8'h46, 16'h7777, 0, 0, 3, 0, 1, 1'b1, 400, 1'b0);
    // R11: flag clears on next request
    run(1'b0, 8'h47, 16'h0, 0, 0, 0, 0, 1, 1'b1, -1, 1'b0);

    // R12: request held valid through a transfer with a changing address
    run(1'b1, 8'h55, 16'hC0DE, 2, 1, 1, 1, 2, 1'b0, -1, 1'b1);
    // the held request (new address below) is taken right at the ack edge
    req_addr = 8'hAA; req_write = 1'b0;
    measure(1'b0, 8'hAA, 16'h0, 3 * 2, 2 * 2, 2 * 2, 2 * 2, 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // req_addr changes while busy in the R12 scenario
  always @(negedge clk)
    if (req_valid && !req_ready && req_addr == 8'h55) req_addr <= 8'hAA;
endmodule